// File: doc/BRIEF.md
# Region Operand Register File

This block is the operand store of a SIMD execution lane group. It keeps 128 registers of 32 bytes each, and any byte in it can be addressed. A single read request gathers up to 16 elements from a two-dimensional region of that storage. The region is given by a starting register, a sub-register index counted in elements, a row pitch (vertical stride), a row width and an element step inside a row (horizontal stride). Each gathered element is widened to a 64-bit lane and placed in one packed result vector. A region may run on into the registers that follow its starting register. A zero horizontal stride repeats one element across its row, and a zero pitch repeats whole rows.

A write request scatters up to 16 lanes into a destination region that has only a horizontal stride. Each lane is cut down to the destination element size before it is stored. A separate whole-register load port fills the file, for example before a test or when a thread is set up.

Top module: `region_operand_file`

## Requirements
- R1: While `rst_n` is low, `rd_valid`, `rd_err` and `rd_data` are all zero.
- R2: When `ld_en` is high at a rising edge, all 256 bits of `ld_data` are stored into register `ld_reg`. Bits [8j+7:8j] become byte j of that register, and byte j sits at file address `ld_reg*32+j`.
- R3: A read sampled with `rd_en` high at edge n drives `rd_valid` high for one cycle after edge n, and its result appears on `rd_data`/`rd_err` at the same time. While `rd_en` is low, `rd_valid` is low and `rd_data`/`rd_err` hold their values.
- R4: The row width is 2^`rd_wlog`. Read lane k has row = k >> `rd_wlog` and column = k mod 2^`rd_wlog`. Its byte address is `rd_reg*32 + (rd_sub + row*rd_vs + column*rd_hs)*size`.
- R5: A read region may continue past byte 31 of its starting register into the registers that follow it.
- R6: A horizontal stride of 0 repeats the first element of each row across that row. With pitch 0, stride 0 and width 1, a single element is broadcast to every active lane.
- R7: The element type code t selects size 2^(t>>1) bytes (0 ub, 1 b, 2 uw, 3 w, 4 ud or float bits, 5 d, 6 uq, 7 q). Odd codes are signed and are sign-extended to 64 bits. Even codes are zero-extended.
- R8: `rd_lanes` (1, 2, 4, 8 or 16) is the execution size. Lanes at or above it read as zero and never raise `rd_err`.
- R9: An active read lane whose element address is 4096 or more returns zero and sets `rd_err` for that result. The other lanes still return their data.
- R10: Write lane k, for k < `wr_lanes`, stores the low size bytes of `wr_data[64k+63:64k]` at `wr_reg*32 + (wr_sub + k*wr_hs)*size`, using the same type codes as R7. Lanes at or above `wr_lanes` leave memory unchanged. Elements whose address is past the end of the file are dropped.
- R11: When write lanes overlap, the highest-numbered lane wins. A region write wins over a load issued in the same cycle. A read issued in the same cycle as a write returns the contents from before that write.
- R12: Multi-byte elements are little-endian: the lowest byte address supplies the least significant byte. Read lane k occupies `rd_data[64k+63:64k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read outputs |
| ld_en | input | 1 | Whole-register load strobe |
| ld_reg | input | 7 | Register to load |
| ld_data | input | 256 | Load data, byte 0 in bits [7:0] |
| rd_en | input | 1 | Region read request |
| rd_reg | input | 7 | Starting register of the read region |
| rd_sub | input | 5 | Starting element index within the register |
| rd_vs | input | 6 | Row pitch in elements |
| rd_wlog | input | 3 | log2 of the row width |
| rd_hs | input | 5 | Element step within a row |
| rd_type | input | 3 | Source element type code |
| rd_lanes | input | 5 | Read execution size |
| rd_valid | output | 1 | Read result is valid this cycle |
| rd_data | output | 1024 | Sixteen widened 64-bit lanes |
| rd_err | output | 1 | An active lane addressed past the file |
| wr_en | input | 1 | Region write request |
| wr_reg | input | 7 | Starting register of the destination |
| wr_sub | input | 5 | Starting element index of the destination |
| wr_hs | input | 5 | Destination element step |
| wr_type | input | 3 | Destination element type code |
| wr_lanes | input | 5 | Write execution size |
| wr_data | input | 1024 | Sixteen 64-bit source lanes |

## Verification
Reads and writes have fixed timing. A read whose request is sampled at rising edge n has its data, error flag and valid strobe due right after edge n. A load or write sampled at edge n is visible to a read sampled at edge n+1. The bench changes inputs on falling edges. When it issues a read, it pushes the expected lanes into a queue, computing them from its own byte-level copy of the file. A monitor pops one entry at the next falling edge each time `rd_valid` is high, so every comparison lands exactly one cycle after its request. Any leftover or unexpected entry is reported.

// File: rtl/region_operand_file.sv
module region_operand_file #(
  parameter int NREGS  = 128,
  parameter int RBYTES = 32,
  parameter int LANES  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [$clog2(NREGS)-1:0]  ld_reg,
  input  logic [RBYTES*8-1:0]       ld_data,
  input  logic                      rd_en,
  input  logic [$clog2(NREGS)-1:0]  rd_reg,
  input  logic [$clog2(RBYTES)-1:0] rd_sub,
  input  logic [5:0]                rd_vs,
  input  logic [2:0]                rd_wlog,
  input  logic [4:0]                rd_hs,
  input  logic [2:0]                rd_type,
  input  logic [$clog2(LANES):0]    rd_lanes,
  output logic                      rd_valid,
  output logic [LANES*64-1:0]       rd_data,
  output logic                      rd_err,
  input  logic                      wr_en,
  input  logic [$clog2(NREGS)-1:0]  wr_reg,
  input  logic [$clog2(RBYTES)-1:0] wr_sub,
  input  logic [4:0]                wr_hs,
  input  logic [2:0]                wr_type,
  input  logic [$clog2(LANES):0]    wr_lanes,
  input  logic [LANES*64-1:0]       wr_data
);
  localparam int RIW   = $clog2(NREGS);
  localparam int BOW   = $clog2(RBYTES);
  localparam int AW    = RIW + BOW;
  localparam int ADW   = AW + 6;
  localparam int LCW   = $clog2(LANES) + 1;
  localparam int RBITS = RBYTES * 8;
  localparam logic [ADW-1:0] LIMIT = ADW'(NREGS * RBYTES);

  function automatic logic [ADW-1:0] elem_addr(input logic [RIW-1:0] r, input logic [BOW-1:0] s,
                                               input logic [ADW-1:0] idx, input logic [1:0] szl);
    return (ADW'(r) << BOW) + ((ADW'(s) + idx) << szl);
  endfunction

  function automatic logic [63:0] widen(input logic [63:0] raw, input logic [2:0] t);
    case (t[2:1])
      2'd0:    widen = t[0] ? {{56{raw[7]}}, raw[7:0]}   : {56'd0, raw[7:0]};
      2'd1:    widen = t[0] ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
      2'd2:    widen = t[0] ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
      default: widen = raw;
    endcase
  endfunction

  logic [RBITS-1:0]       regs [NREGS];
  logic [LANES-1:0][63:0] lane_val;
  logic [LANES-1:0]       lane_err;
  logic [ADW-1:0]         wa [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADW-1:0]   row, col, ra;
    logic [RBITS-1:0] word;
    logic             act, oob;
    assign row = ADW'(k) >> rd_wlog;
    assign col = ADW'(k) & ((ADW'(1) << rd_wlog) - ADW'(1));
    assign ra  = elem_addr(rd_reg, rd_sub, row * ADW'(rd_vs) + col * ADW'(rd_hs), rd_type[2:1]);
    assign oob = ra >= LIMIT;
    assign act = LCW'(k) < rd_lanes;
    assign word = regs[ra[AW-1:BOW]] >> {ra[BOW-1:0], 3'b000};
    assign lane_val[k] = (act && !oob) ? widen(word[63:0], rd_type) : 64'd0;
    assign lane_err[k] = act && oob;
    assign wa[k] = elem_addr(wr_reg, wr_sub, ADW'(k) * ADW'(wr_hs), wr_type[2:1]);
  end

  always_ff @(posedge clk) begin
    if (ld_en) regs[ld_reg] <= ld_data;
    if (wr_en)
      for (int k = 0; k < LANES; k++)
        if (LCW'(k) < wr_lanes && wa[k] < LIMIT)
          for (int j = 0; j < 8; j++)
            if (j < (1 << wr_type[2:1]))
              regs[wa[k][AW-1:BOW]][(int'(wa[k][BOW-1:0]) + j) * 8 +: 8] <= wr_data[(k * 8 + j) * 8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= lane_val;
        rd_err  <= |lane_err;
      end
    end
  end
endmodule

module region_operand_file_chk #(
  parameter int LANES = 16,
  parameter int SUBW  = 5,
  parameter int LCW   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_en,
  input logic [SUBW-1:0]      rd_sub,
  input logic [5:0]           rd_vs,
  input logic [4:0]           rd_hs,
  input logic [LCW-1:0]       rd_lanes,
  input logic                 rd_valid,
  input logic [LANES*64-1:0]  rd_data,
  input logic                 rd_err
);
  // R3
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid);
  // R3
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rd_data) && $stable(rd_err)));
  // R8
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_lanes == LCW'(1)) |=> (rd_data[LANES*64-1:64] == '0));
  // R9
  no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_vs == 6'd0 && rd_hs == 5'd0 && rd_sub == '0) |=> !rd_err);
endmodule

bind region_operand_file region_operand_file_chk #(
  .LANES(LANES), .SUBW($clog2(RBYTES)), .LCW($clog2(LANES) + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sub(rd_sub), .rd_vs(rd_vs), .rd_hs(rd_hs),
  .rd_lanes(rd_lanes), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
);

// File: tb/test_region_operand_file.sv
module test_region_operand_file;
  localparam int NL = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, ld_en, rd_en, wr_en, rd_valid, rd_err;
  logic [6:0]    ld_reg, rd_reg, wr_reg;
  logic [255:0]  ld_data;
  logic [4:0]    rd_sub, rd_hs, rd_lanes, wr_sub, wr_hs, wr_lanes;
  logic [5:0]    rd_vs;
  logic [2:0]    rd_wlog, rd_type, wr_type;
  logic [1023:0] rd_data, wr_data;

  region_operand_file i_region_operand_file (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_reg(ld_reg), .ld_data(ld_data),
    .rd_en(rd_en), .rd_reg(rd_reg), .rd_sub(rd_sub), .rd_vs(rd_vs), .rd_wlog(rd_wlog),
    .rd_hs(rd_hs), .rd_type(rd_type), .rd_lanes(rd_lanes), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sub(wr_sub),
    .wr_hs(wr_hs), .wr_type(wr_type), .wr_lanes(wr_lanes), .wr_data(wr_data)
  );

  logic [7:0]    mem [4096];
  logic [1024:0] exp_q [$];
  string         tag_q [$];
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  function automatic logic [63:0] sx(input logic [63:0] raw, input int t);
    case (t >> 1)
      0:       return (t % 2) ? {{56{raw[7]}}, raw[7:0]}   : {56'd0, raw[7:0]};
      1:       return (t % 2) ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
      2:       return (t % 2) ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
      default: return raw;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
    ld_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_load(input int r);
    ld_en = 1'b1; ld_reg = 7'(r);
    for (int j = 0; j < 32; j++) begin
      logic [7:0] b;
      b = 8'(r * 37 + j * 11 + 5);
      ld_data[8*j +: 8] = b;
      mem[r*32 + j] = b;
    end
  endtask

  task automatic set_read(input string tag, input int r, input int sub, input int vs,
                          input int wlog, input int hs, input int t, input int lanes);
    logic [1023:0] e;
    logic er;
    int sz;
    e = '0; er = 1'b0; sz = 1 << (t >> 1);
    for (int k = 0; k < NL; k++) begin
      if (k < lanes) begin
        int a;
        a = r*32 + (sub + (k >> wlog)*vs + (k % (1 << wlog))*hs) * sz;
        if (a >= 4096) er = 1'b1;
        else begin
          logic [63:0] raw;
          raw = '0;
          for (int j = 0; j < sz; j++) raw[8*j +: 8] = mem[a + j];
          e[64*k +: 64] = sx(raw, t);
        end
      end
    end
    rd_en = 1'b1; rd_reg = 7'(r); rd_sub = 5'(sub); rd_vs = 6'(vs); rd_wlog = 3'(wlog);
    rd_hs = 5'(hs); rd_type = 3'(t); rd_lanes = 5'(lanes);
    exp_q.push_back({er, e});
    tag_q.push_back(tag);
  endtask

  task automatic set_write(input int r, input int sub, input int hs, input int t,
                           input int lanes, input logic [63:0] seed);
    int sz;
    sz = 1 << (t >> 1);
    for (int k = 0; k < NL; k++) wr_data[64*k +: 64] = seed ^ (64'(k) * 64'h0123_4567_89AB_CDEF);
    wr_en = 1'b1; wr_reg = 7'(r); wr_sub = 5'(sub); wr_hs = 5'(hs);
    wr_type = 3'(t); wr_lanes = 5'(lanes);
    for (int k = 0; k < lanes; k++) begin
      int a;
      a = r*32 + (sub + k*hs) * sz;
      if (a < 4096)
        for (int j = 0; j < sz; j++) mem[a + j] = wr_data[64*k + 8*j +: 8];
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected rd_valid actual=1 expected=0");
      end else begin
        logic [1024:0] x;
        string tg;
        x = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (rd_data !== x[1023:0]) begin
          fails++;
          $display("FAIL %s data actual=%h expected=%h", tg, rd_data, x[1023:0]);
        end
        checks++;
        if (rd_err !== x[1024]) begin
          fails++;
          $display("FAIL %s err actual=%b expected=%b", tg, rd_err, x[1024]);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [1023:0] hd;
    logic he;
    logic [31:0] s;
    int vsel [7];
    int hsel [4];
    vsel = '{0, 1, 2, 4, 8, 16, 32};
    hsel = '{0, 1, 2, 4};
    s = 32'h1ACE_B00C;
    rst_n = 1'b0; ld_en = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    ld_reg = '0; ld_data = '0; rd_reg = '0; rd_sub = '0; rd_vs = '0; rd_wlog = '0;
    rd_hs = '0; rd_type = '0; rd_lanes = '0; wr_reg = '0; wr_sub = '0; wr_hs = '0;
    wr_type = '0; wr_lanes = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_err !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b/%b expected=0/0", rd_valid, rd_err);
    end
    rst_n = 1'b1;

    for (int r = 0; r < 128; r++) begin tick(); set_load(r); end

    tick(); set_read("R2 load bytes low", 0, 0, 16, 4, 1, 0, 16);
    tick(); set_read("R2 load bytes high", 77, 16, 16, 4, 1, 0, 16);
    tick(); set_read("R12 little-endian dwords", 0, 0, 4, 2, 1, 4, 4);
    tick(); set_read("R4 region 16;8,2 words", 4, 1, 16, 3, 2, 3, 16);
    tick(); set_read("R4 region 1;8,2 words", 5, 0, 1, 3, 2, 3, 16);
    tick(); set_read("R5 cross r1.7 bytes", 1, 7, 16, 3, 1, 1, 16);
    tick(); set_read("R5 cross r2.17 bytes", 2, 17, 16, 3, 1, 1, 16);
    tick(); set_read("R6 repeat hs0 bytes", 1, 14, 16, 3, 0, 1, 16);
    tick(); set_read("R6 scalar broadcast", 3, 5, 0, 0, 0, 5, 8);
    for (int t = 0; t < 8; t++) begin tick(); set_read("R7 type widening", 10, 0, 4, 2, 1, t, 4); end
    tick(); set_read("R8 one lane", 5, 0, 8, 3, 1, 4, 1);
    tick(); set_read("R8 two lanes", 5, 0, 8, 3, 1, 4, 2);
    tick(); set_read("R9 past end qwords", 127, 0, 8, 3, 1, 7, 8);
    tick(); set_read("R9 spill into r127 ok", 126, 30, 4, 2, 1, 0, 4);

    tick();
    tick();
    hd = rd_data; he = rd_err;
    repeat (3) tick();
    checks++;
    if (rd_data !== hd || rd_err !== he || rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL R3 hold actual=%h expected=%h", rd_data, hd);
    end

    tick(); set_write(20, 2, 1, 3, 16, 64'h8001_7F02_FF80_A5C3);
    tick(); set_read("R10 word write r20", 20, 0, 16, 4, 1, 2, 16);
    tick(); set_read("R10 word write r21", 21, 0, 16, 4, 1, 2, 16);
    tick(); set_write(30, 3, 2, 0, 5, 64'h0000_0000_0000_00F0);
    tick(); set_read("R10 byte stride low", 30, 0, 16, 4, 1, 0, 16);
    tick(); set_read("R10 byte stride high", 30, 16, 16, 4, 1, 0, 16);
    tick(); set_write(127, 6, 1, 4, 4, 64'h1234_5678_DEAD_BEEF);
    tick(); set_read("R10 write dropped past end", 127, 0, 8, 3, 1, 4, 8);
    tick(); set_read("R10 write no wrap to r0", 0, 0, 8, 3, 1, 4, 8);

    tick(); set_write(40, 1, 0, 4, 3, 64'hCAFE_0000_0000_0101);
    tick(); set_read("R11 overlap last lane", 40, 0, 4, 2, 1, 4, 4);
    tick(); set_load(41); set_write(41, 0, 1, 2, 2, 64'h0000_0000_0000_9999);
    tick(); set_read("R11 write over load", 41, 0, 16, 4, 1, 0, 16);
    tick(); set_read("R11 read before write", 20, 0, 4, 2, 1, 6, 4);
    set_write(20, 0, 1, 6, 4, 64'hF00D_F00D_0BAD_CAFE);
    tick(); set_read("R11 read after write", 20, 0, 4, 2, 1, 6, 4);
    tick(); set_read("R12 back-to-back", 20, 0, 16, 4, 1, 0, 16);

    for (int n = 0; n < 60; n++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      tick();
      set_read("R4 random region", int'(s[6:0]), int'(s[11:7]), vsel[int'(s[14:12]) % 7],
               int'(s[19:17]) % 5, hsel[int'(s[16:15])], int'(s[22:20]),
               1 << (int'(s[25:23]) % 5));
    end

    repeat (3) tick();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule